// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block is the master side of a four-wire serial link to a NOR-style serial flash. A host gives it one operation (read, program or erase), a 24-bit byte address and, for program, one data byte, then pulses `start`. The block drops chip select and clocks out an opcode followed by the address. For a read it then clocks in one data byte. For a program it clocks out the data byte. For an erase it sends nothing after the address. Every clock cycle is full duplex: the same shift register sends a bit out on MOSI and takes a bit in from MISO.

The link has no acknowledge or flow control. After a program or an erase the block therefore waits on the flash by itself. It releases chip select and then runs short status frames, each with chip select low for the whole frame: the status opcode, then one status byte shifted in. It repeats these frames until the busy bit reads clear. A programmable poll limit bounds the wait. If the limit is reached, the block reports an error together with `done`.

The serial clock is derived from the system clock by a programmable divider. The clock runs only while a frame is active.

Top module: `sflash_seq`

## Requirements
- R1: While `rst` is high and after it falls, `spi_cs_n` is 1 and `spi_sck`, `busy`, `done` and `err` are 0.
- R2: In every frame, `spi_cs_n` falls exactly `div+1` system clocks before the first rising edge of `spi_sck`. It rises exactly `div+1` clocks after the last falling edge. `spi_sck` is low whenever `spi_cs_n` is high.
- R3: `spi_sck` idles low. Consecutive rising edges are `2*(div+1)` system clocks apart. `spi_mosi` does not change while `spi_sck` is high. MISO is sampled on the rising edge.
- R4: Every frame starts with an 8-bit opcode followed by the 24-bit address. All fields are sent most significant bit first. The `op` encoding is: 0 = read (opcode 0x03), 1 = program (0x02), 2 = erase (0xD8), 3 = read.
- R5: A read frame has 40 clocks. The last 8 clocks send 0x00 and shift MISO in, MSB first. The result is on `rdata` when `done` pulses, with `err` = 0.
- R6: A program frame has 40 clocks. The last 8 send `wdata` MSB first.
- R7: An erase frame has 32 clocks and no data phase.
- R8: After a program or an erase frame, the block runs status frames. Each has 16 clocks, sends 0x05 then 0x00, and takes in the status byte. Chip select is high for `div+1` clocks between frames. Polling stops when bit 0 of the received status is 0, and then `done` pulses with `err` = 0.
- R9: If every one of `max_poll` status reads reports busy, `done` pulses with `err` = 1 after that many frames. A `max_poll` of 0 behaves as 1. A clear status on the last allowed read counts as success.
- R10: `start` is ignored while `busy` is 1. The request inputs are captured only when a start is accepted.
- R11: `done` is a one-cycle pulse. `busy` falls in the same cycle. A `start` presented in the cycle `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken when not busy |
| op | input | 2 | Operation: 0 read, 1 program, 2 erase, 3 read |
| addr | input | 24 | Flash byte address |
| wdata | input | 8 | Byte to program |
| div | input | 8 | Clock divider; SCK period is 2*(div+1) clocks |
| max_poll | input | 16 | Maximum number of status reads |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll limit reached; valid with done |
| rdata | output | 8 | Byte read; valid with done |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Two decisions can land on the same status read: reaching the poll limit and seeing the busy bit clear. The bench provokes this by setting the flash model's busy count to exactly one less than `max_poll`, and also to equal it and exceed it. The scoreboard then expects success, error and error, together with the exact number of status frames. The bench also raises `start` in the very cycle `done` pulses, so that completion and a new acceptance coincide. It checks that the second frame follows with the new opcode, while a start raised in the middle of an operation leaves no trace in the captured frames.

// File: rtl/sflash_pkg.sv
`timescale 1ns/1ps
package sflash_pkg;

  typedef enum logic [1:0] {
    SF_READ     = 2'd0,
    SF_PROG     = 2'd1,
    SF_ERASE    = 2'd2,
    SF_READ_ALT = 2'd3
  } sf_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_HOLD,
    ST_GAP
  } sf_state_e;

  localparam logic [7:0] CMD_READ   = 8'h03;
  localparam logic [7:0] CMD_PROG   = 8'h02;
  localparam logic [7:0] CMD_ERASE  = 8'hD8;
  localparam logic [7:0] CMD_STATUS = 8'h05;

  function automatic logic [7:0] sf_opcode(input logic [1:0] o);
    case (o)
      2'd1:    return CMD_PROG;
      2'd2:    return CMD_ERASE;
      default: return CMD_READ;
    endcase
  endfunction

endpackage

// File: rtl/sflash_clkdiv.sv
`timescale 1ns/1ps
// Half-period tick generator: one tick every div+1 clocks while enabled.
module sflash_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/sflash_shift.sv
`timescale 1ns/1ps
// Full-duplex shift engine: the outgoing word drains from the top while
// sampled MISO bits fill in from the bottom.
module sflash_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         sample,
  input  logic         shift,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_word,
  output logic         last_bit
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]     sreg;
  logic             rxb;
  logic [CNT_W-1:0] cnt;

  assign mosi     = sreg[W-1];
  assign rx_word  = {sreg[W-2:0], rxb};
  assign last_bit = (cnt == CNT_W'(W-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      rxb  <= 1'b0;
      cnt  <= '0;
    end else begin
      if (sample) rxb <= miso;
      if (load) begin
        sreg <= load_val;
        cnt  <= '0;
      end else if (shift) begin
        sreg <= rx_word;
        cnt  <= cnt + CNT_W'(1);
      end
    end
  end

  // R3: a new word is never loaded on the same edge that shifts the old one
  assert_load_shift_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(load && shift));
endmodule

// File: rtl/sflash_seq.sv
`timescale 1ns/1ps
module sflash_seq
  import sflash_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DIV_W  = 8,
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [DIV_W-1:0]  div,
  input  logic [POLL_W-1:0] max_poll,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [7:0]        rdata,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int WORD_W     = 8;
  localparam int ADDR_BYTES = ADDR_W / WORD_W;
  localparam int IDX_W      = $clog2(ADDR_BYTES + 2);
  localparam logic [IDX_W-1:0] IDX_ADDR_END = IDX_W'(ADDR_BYTES);
  localparam logic [IDX_W-1:0] IDX_DATA     = IDX_W'(ADDR_BYTES + 1);

  sf_state_e          state;
  logic [1:0]         op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [7:0]         wdata_q;
  logic [DIV_W-1:0]   div_q;
  logic [POLL_W-1:0]  maxp_q;
  logic [POLL_W-1:0]  pcnt;
  logic [POLL_W-1:0]  pcnt_nx;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   nxt_idx;
  logic [IDX_W-1:0]   last_idx;
  logic               polling;
  logic [WORD_W-1:0]  rx_last;
  logic               is_read;

  logic               tick;
  logic               sh_load, sh_sample, sh_shift, sh_last;
  logic [WORD_W-1:0]  sh_load_val, sh_rx;
  logic [WORD_W-1:0]  byte_nx;
  logic [WORD_W-1:0]  addr_bytes [ADDR_BYTES];

  // Address bytes, most significant first
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
    assign addr_bytes[g] = addr_q[ADDR_W-1-WORD_W*g -: WORD_W];
  end

  assign is_read  = (op_q != SF_PROG) && (op_q != SF_ERASE);
  assign pcnt_nx  = pcnt + POLL_W'(1);
  assign nxt_idx  = idx + IDX_W'(1);
  assign last_idx = polling ? IDX_W'(1) :
                    (op_q == SF_ERASE) ? IDX_ADDR_END : IDX_DATA;

  always_comb begin
    byte_nx = (op_q == SF_PROG) ? wdata_q : '0;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (nxt_idx == IDX_W'(k + 1)) byte_nx = addr_bytes[k];
  end

  always_comb begin
    if (state == ST_IDLE)     sh_load_val = sf_opcode(op);
    else if (state == ST_GAP) sh_load_val = CMD_STATUS;
    else if (polling)         sh_load_val = '0;
    else                      sh_load_val = byte_nx;
  end

  assign sh_load   = (state == ST_IDLE && start) ||
                     (state == ST_GAP && tick) ||
                     (state == ST_HI && tick && sh_last && idx != last_idx);
  assign sh_sample = (state == ST_LO) && tick;
  assign sh_shift  = (state == ST_HI) && tick && !sh_load;

  sflash_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .en   (state != ST_IDLE),
    .div  (div_q),
    .tick (tick)
  );

  sflash_shift #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (sh_load),
    .load_val (sh_load_val),
    .sample   (sh_sample),
    .shift    (sh_shift),
    .miso     (spi_miso),
    .mosi     (spi_mosi),
    .rx_word  (sh_rx),
    .last_bit (sh_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      spi_cs_n <= 1'b1;
      spi_sck  <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      rdata    <= '0;
      op_q     <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      div_q    <= '0;
      maxp_q   <= '0;
      pcnt     <= '0;
      idx      <= '0;
      polling  <= 1'b0;
      rx_last  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          op_q     <= op;
          addr_q   <= addr;
          wdata_q  <= wdata;
          div_q    <= div;
          maxp_q   <= max_poll;
          busy     <= 1'b1;
          err      <= 1'b0;
          spi_cs_n <= 1'b0;
          idx      <= '0;
          pcnt     <= '0;
          polling  <= 1'b0;
          state    <= ST_LO;
        end
        ST_LO: if (tick) begin
          spi_sck <= 1'b1;
          state   <= ST_HI;
        end
        ST_HI: if (tick) begin
          spi_sck <= 1'b0;
          state   <= ST_LO;
          if (sh_last) begin
            if (idx == last_idx) begin
              rx_last <= sh_rx;
              state   <= ST_HOLD;
            end else begin
              idx <= nxt_idx;
            end
          end
        end
        ST_HOLD: if (tick) begin
          spi_cs_n <= 1'b1;
          if (!polling && is_read) begin
            rdata <= rx_last;
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else if (!polling) begin
            state <= ST_GAP;
          end else if (!rx_last[0]) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else if (pcnt_nx >= maxp_q) begin
            err   <= 1'b1;
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            pcnt  <= pcnt_nx;
            state <= ST_GAP;
          end
        end
        ST_GAP: if (tick) begin
          spi_cs_n <= 1'b0;
          polling  <= 1'b1;
          idx      <= '0;
          state    <= ST_LO;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: the serial clock never leaves its idle level while the flash is deselected
  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);

  // R3: MOSI holds while the clock is high
  assert_mosi_fall_only_R3: assert property (@(posedge clk) disable iff (rst)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  // R10: a captured request does not change during an operation
  assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(op_q) && $stable(addr_q) && $stable(wdata_q)));

  // R11: done ends an operation and busy drops with it
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));

  // R9: an error is only raised together with completion
  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);
endmodule

// File: tb/sflash_seq_tb.sv
`timescale 1ns/1ps
module sflash_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic [23:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  div = '0;
  logic [15:0] max_poll = '0;
  logic        miso = 1'b0;
  logic        busy, done, err, cs_n, sck, mosi;
  logic [7:0]  rdata;

  always #2.5 clk = ~clk;

  sflash_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .addr(addr), .wdata(wdata),
    .div(div), .max_poll(max_poll), .busy(busy), .done(done), .err(err),
    .rdata(rdata), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard queues: {length, bits} per frame and {check_rdata, err, rdata} per op
  logic [71:0] exp_fr [$];
  logic [9:0]  exp_res [$];

  // Flash model configuration
  int        m_busy_polls = 0;
  int        m_polls = 0;
  logic [7:0] m_rd = '0;
  int        cur_div = 0;

  // Flash model and timing monitor
  logic        pcs = 1'b1, psck = 1'b0, pmosi = 1'b0;
  longint      cyc = 0, t_cs = 0, t_rise = 0, t_fall = 0;
  int          nb = 0;
  logic [63:0] cap = '0;
  logic [7:0]  mop = '0;
  bit          bad_per = 0, bad_mosi = 0;
  logic [7:0]  st;
  logic [71:0] e;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (pcs && !cs_n) begin
        nb = 0; cap = '0; mop = '0; bad_per = 0; bad_mosi = 0; t_cs = cyc; miso = 1'b0;
      end
      if (!cs_n && sck && !psck) begin
        if (nb == 0)
          chk(cyc - t_cs == longint'(cur_div + 1), "R2 cs setup",
              64'(cyc - t_cs), 64'(cur_div + 1));
        else if (cyc - t_rise != longint'(2 * (cur_div + 1)))
          bad_per = 1;
        t_rise = cyc;
        cap = {cap[62:0], mosi};
        nb++;
        if (nb == 8) mop = cap[7:0];
      end
      if (!cs_n && sck && psck && mosi != pmosi) bad_mosi = 1;
      if (!cs_n && !sck && psck) begin
        t_fall = cyc;
        st = 8'hA4 | {7'd0, (m_polls < m_busy_polls)};
        if (mop == 8'h05 && nb >= 8)                miso = st[7 - ((nb - 8) % 8)];
        else if (mop == 8'h03 && nb >= 32 && nb < 40) miso = m_rd[39 - nb];
        else                                         miso = 1'b0;
      end
      if (!pcs && cs_n) begin
        chk(cyc - t_fall == longint'(cur_div + 1), "R2 cs hold",
            64'(cyc - t_fall), 64'(cur_div + 1));
        chk(!bad_per, "R3 sck period", 64'(bad_per), 64'd0);
        chk(!bad_mosi, "R3 mosi changed while sck high", 64'(bad_mosi), 64'd0);
        if (exp_fr.size() == 0) begin
          chk(0, "R10 unexpected frame", cap, 64'd0);
        end else begin
          e = exp_fr.pop_front();
          chk(nb == int'(e[71:64]) && cap == e[63:0],
              (e[63:56] == 8'h05 || e[15:8] == 8'h05) ? "R8 status frame" :
              (e[71:64] == 8'd32) ? "R4/R7 erase frame" :
              (e[63:56] == 8'h02) ? "R4/R6 program frame" : "R4/R5 read frame",
              {nb[7:0], cap[55:0]}, {e[71:64], e[55:0]});
        end
        if (mop == 8'h05) m_polls++;
      end
    end
    pcs = cs_n; psck = sck; pmosi = mosi;
  end

  // Result monitor
  logic       pdone = 1'b0;
  logic [9:0] r;
  always @(negedge clk) begin
    if (!rst) begin
      if (done && pdone) chk(0, "R11 done longer than one cycle", 64'd1, 64'd0);
      if (done) begin
        chk(!busy, "R11 busy low with done", 64'(busy), 64'd0);
        if (exp_res.size() == 0) begin
          chk(0, "R10 unexpected done", 64'd1, 64'd0);
        end else begin
          r = exp_res.pop_front();
          chk(err == r[8], r[8] ? "R9 err at poll limit" : "R8 err clear",
              64'(err), 64'(r[8]));
          if (r[9]) chk(rdata == r[7:0], "R5 rdata", 64'(rdata), 64'(r[7:0]));
        end
      end
    end
    pdone = done;
  end

  // Driver: pushes the expected frames and result, then requests the operation
  task automatic issue(input logic [1:0] o, input logic [23:0] a, input logic [7:0] wd,
                       input int dv, input int mp, input int bp, input logic [7:0] rb);
    int eff, np;
    logic [7:0] opc;
    #1;
    eff = (mp == 0) ? 1 : mp;
    np  = (bp + 1 < eff) ? bp + 1 : eff;
    opc = (o == 2'd1) ? 8'h02 : (o == 2'd2) ? 8'hD8 : 8'h03;
    if (o == 2'd2) exp_fr.push_back({8'd32, 32'd0, opc, a});
    else           exp_fr.push_back({8'd40, 24'd0, opc, a, (o == 2'd1) ? wd : 8'h00});
    if (o == 2'd1 || o == 2'd2) begin
      for (int i = 0; i < np; i++) exp_fr.push_back({8'd16, 64'h0500});
      exp_res.push_back({1'b0, (bp >= eff), 8'h00});
    end else begin
      exp_res.push_back({1'b1, 1'b0, rb});
    end
    m_busy_polls = bp; m_polls = 0; m_rd = rb; cur_div = dv;
    op = o; addr = a; wdata = wd; div = 8'(dv); max_poll = 16'(mp);
    start = 1'b1;
    @(negedge clk);
    #1 start = 1'b0;
    chk(busy == 1'b1, "R10 busy after accepted start", 64'(busy), 64'd1);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0, "R1 link idle in reset", {cs_n, sck}, 2'b10);
    chk(!busy && !done && !err, "R1 status clear in reset", {busy, done, err}, 3'b000);
    #1 rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && !busy, "R1 idle after reset", {cs_n, busy}, 2'b10);

    issue(2'd0, 24'h123456, 8'h00, 0, 1, 0, 8'h5A); wait_done();            // R5 read
    issue(2'd1, 24'hA0B1C2, 8'h3C, 1, 5, 2, 8'h00); wait_done();            // R6, R8
    issue(2'd2, 24'h00FF00, 8'h00, 2, 4, 0, 8'h00); wait_done();            // R7, R8
    issue(2'd1, 24'h0F0F0F, 8'hC3, 0, 3, 4, 8'h00); wait_done();            // R9 err
    issue(2'd2, 24'h765432, 8'h00, 1, 3, 2, 8'h00); wait_done();            // R9 clear on last read
    issue(2'd1, 24'h000001, 8'h81, 0, 0, 1, 8'h00); wait_done();            // R9 zero limit
    issue(2'd3, 24'hFEDCBA, 8'h00, 1, 1, 0, 8'hA5);                         // R4 op 3 reads
    repeat (20) @(negedge clk);
    #1 op = 2'd2; addr = 24'h111111; start = 1'b1;                          // R10 ignored start
    @(negedge clk);
    #1 start = 1'b0;
    chk(busy == 1'b1, "R10 busy held through ignored start", 64'(busy), 64'd1);
    wait_done();
    issue(2'd0, 24'h0000AA, 8'h00, 3, 1, 0, 8'h96);                         // R11 back-to-back
    wait_done();
    issue(2'd1, 24'h2468AC, 8'h7E, 0, 2, 1, 8'h00); wait_done();            // R11 back-to-back program
    repeat (20) @(negedge clk);
    chk(exp_fr.size() == 0, "R10 all frames seen", 64'(exp_fr.size()), 64'd0);
    chk(exp_res.size() == 0, "R11 all results seen", 64'(exp_res.size()), 64'd0);
    chk(cs_n == 1'b1 && !busy, "R2 idle at end", {cs_n, busy}, 2'b10);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end
endmodule